// File: doc/BRIEF.md
# Commutation-Aware Three-Phase PWM Generator

This block drives the six gate signals, one high-side and one low-side switch for each of three motor phases, of a six-step brushless DC inverter. The switching period is fixed and set by a terminal-count input. A free-running counter runs from zero up to that value, and the on-time of each period is compared against it. In steady conduction the block chops only two phases: the high-side switch of the conducting pair is chopped with the on-time from the outer control loop, and the matching low-side switch is held on.

When the commutation flag is raised, the block switches to three-phase chopping for the sector being entered. The switch of the incoming phase is held on. The switches of the phase that keeps its current and of the outgoing phase are chopped together. The on-time used for this comes from one of two precomputed commutation values, chosen by the parity of the sector. Each value is the period scaled by one third plus four thirds of the back-EMF estimate over the link voltage. With this duty the incoming and outgoing currents ramp at equal and opposite rates.

Sector, mode, period and all on-times are captured only at a period boundary. A one-cycle strobe marks every on/off transition of the chop waveform, so that a downstream current-zero detector can blank its sampling around switching points.

Top module: `pwm_cmt_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, all six gate outputs and the strobe are low.
- R2: Phases are indexed A=0, B=1, C=2, and that index is the bit position in both gate buses. Sectors 1 to 6 conduct (high phase, low phase) = (A,B), (A,C), (B,C), (B,A), (C,A), (C,B). With the commutation flag low, the high-side gate of the high phase is chopped with the normal on-time, the low-side gate of the low phase is held on, and every other gate is off.
- R3: With the flag high in an even sector s, the high-side gate of the high phase of s and the low-side gate of the low phase of the preceding sector (the sector before 1 is 6) are chopped with the even commutation on-time. The low-side gate of the low phase of s is held on, and every other gate is off.
- R4: With the flag high in an odd sector s, the low-side gate of the low phase of s and the high-side gate of the high phase of the preceding sector are chopped with the odd commutation on-time. The high-side gate of the high phase of s is held on, and every other gate is off.
- R5: A chopped gate is on for min(on-time, period length) cycles of each period. An on-time of 0 keeps it off, and an on-time at or above the period length keeps it on.
- R6: The period length is the terminal-count input plus one cycle, and the pattern repeats with exactly that length.
- R7: Changes to sector, flag, terminal count or any on-time take effect only from the next period boundary. The remainder of the current period is unaffected.
- R8: Sector codes 0 and 7 turn all six gates off.
- R9: The high-side and low-side gates of one phase are never on in the same cycle.
- R10: The strobe is high for exactly the cycles in which the chop waveform changes level: twice per period when 0 < effective on-time < period length, otherwise never. The waveform follows the normal on-time when the flag is low, and otherwise the even or odd commutation on-time chosen by sector bit 0, even for invalid sectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_last_i | input | CNT_W | Terminal count; period length is this plus one |
| sector_i | input | 3 | Sector code, 1 to 6 valid |
| comm_i | input | 1 | Commutation flag, selects three-phase chopping |
| ton_norm_i | input | CNT_W | On-time for two-phase chopping |
| ton_even_i | input | CNT_W | Commutation on-time for sectors 2, 4, 6 |
| ton_odd_i | input | CNT_W | Commutation on-time for sectors 1, 3, 5 |
| gate_hi_o | output | 3 | High-side gates, bit = phase index |
| gate_lo_o | output | 3 | Low-side gates, bit = phase index |
| chop_edge_o | output | 1 | One-cycle pulse on each chop transition |

## Verification
Every sector code, valid and invalid, is driven in both modes with random terminal counts and on-times, including ones that are zero or past the period length. For each run the on-cycles of all six gates are counted over whole periods. These counts separate held, chopped and idle switches, and show whether the wrong sector table, the wrong sector parity or the wrong on-time source was used. Directed runs cover the on-time extremes and a mid-period change of on-time, which exposes loading outside the boundary. A multi-period window exposes an off-by-one in the period length.

// File: rtl/pwm_cmt_pkg.sv
package pwm_cmt_pkg;

    typedef enum logic {
        MODE_TWO_PHASE   = 1'b0,
        MODE_THREE_PHASE = 1'b1
    } chop_mode_e;

    // conducting pair of a sector: phase index driven high and low
    typedef struct packed {
        logic [1:0] top;
        logic [1:0] bot;
    } leg_pair_t;

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
    } gate_set_t;

    function automatic logic sector_valid(input logic [2:0] sec);
        return (sec != 3'd0) && (sec != 3'd7);
    endfunction

    function automatic leg_pair_t pair_of(input logic [2:0] sec);
        leg_pair_t p;
        case (sec)
            3'd1:    p = '{top: 2'd0, bot: 2'd1};
            3'd2:    p = '{top: 2'd0, bot: 2'd2};
            3'd3:    p = '{top: 2'd1, bot: 2'd2};
            3'd4:    p = '{top: 2'd1, bot: 2'd0};
            3'd5:    p = '{top: 2'd2, bot: 2'd0};
            3'd6:    p = '{top: 2'd2, bot: 2'd1};
            default: p = '{top: 2'd0, bot: 2'd0};
        endcase
        return p;
    endfunction

    function automatic logic [2:0] prev_sector(input logic [2:0] sec);
        return (sec == 3'd1) ? 3'd6 : 3'(sec - 3'd1);
    endfunction

    function automatic logic [2:0] phase_bit(input logic [1:0] ph);
        return 3'b001 << ph;
    endfunction

endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
    import pwm_cmt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] last_i,
    input  logic [2:0]       sector_i,
    input  logic             comm_i,
    input  logic [CNT_W-1:0] ton_norm_i,
    input  logic [CNT_W-1:0] ton_even_i,
    input  logic [CNT_W-1:0] ton_odd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] last_o,
    output logic [2:0]       sector_o,
    output chop_mode_e       mode_o,
    output logic [CNT_W-1:0] ton_norm_o,
    output logic [CNT_W-1:0] ton_even_o,
    output logic [CNT_W-1:0] ton_odd_o
);

    logic wrap;
    assign wrap = (cnt_o == last_o);

    // last_o resets to zero so the first edge after reset is a boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o      <= '0;
            last_o     <= '0;
            sector_o   <= 3'd0;
            mode_o     <= MODE_TWO_PHASE;
            ton_norm_o <= '0;
            ton_even_o <= '0;
            ton_odd_o  <= '0;
        end else if (wrap) begin
            cnt_o      <= '0;
            last_o     <= last_i;
            sector_o   <= sector_i;
            mode_o     <= chop_mode_e'(comm_i);
            ton_norm_o <= ton_norm_i;
            ton_even_o <= ton_even_i;
            ton_odd_o  <= ton_odd_i;
        end else begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    a_r6_cnt_within_period: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= last_o);

    a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        (cnt_o != last_o) |=> ($stable(sector_o) && $stable(mode_o) && $stable(last_o)
                               && $stable(ton_norm_o) && $stable(ton_even_o) && $stable(ton_odd_o)));

endmodule

// File: rtl/pwm_chop_cmp.sv
module pwm_chop_cmp
    import pwm_cmt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] last_i,
    input  logic [2:0]       sector_i,
    input  chop_mode_e       mode_i,
    input  logic [CNT_W-1:0] ton_norm_i,
    input  logic [CNT_W-1:0] ton_even_i,
    input  logic [CNT_W-1:0] ton_odd_i,
    output logic             chop_o,
    output logic             edge_o
);

    localparam int EW = CNT_W + 1;

    logic [CNT_W-1:0] ton_sel;
    logic [EW-1:0]    period_len;
    logic [EW-1:0]    ton_eff;
    logic             chop_q;

    always_comb begin
        if (mode_i == MODE_TWO_PHASE)
            ton_sel = ton_norm_i;
        else if (sector_i[0])
            ton_sel = ton_odd_i;
        else
            ton_sel = ton_even_i;
    end

    assign period_len = {1'b0, last_i} + 1'b1;
    assign ton_eff    = ({1'b0, ton_sel} > period_len) ? period_len : {1'b0, ton_sel};
    assign chop_o     = ({1'b0, cnt_i} < ton_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            chop_q <= 1'b0;
            edge_o <= 1'b0;
        end else begin
            chop_q <= chop_o;
            edge_o <= chop_o ^ chop_q;
        end
    end

    a_r5_full_on: assert property (@(posedge clk) disable iff (rst)
        (ton_eff == period_len) |-> chop_o);

    a_r5_zero_off: assert property (@(posedge clk) disable iff (rst)
        (ton_sel == '0) |-> !chop_o);

endmodule

// File: rtl/pwm_gate_map.sv
module pwm_gate_map
    import pwm_cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sector_i,
    input  chop_mode_e mode_i,
    input  logic       chop_i,
    output gate_set_t  gates_o
);

    leg_pair_t cur;
    leg_pair_t prv;
    gate_set_t nxt;

    always_comb begin
        cur = pair_of(sector_i);
        prv = pair_of(prev_sector(sector_i));
        nxt = '0;
        if (sector_valid(sector_i)) begin
            if (mode_i == MODE_TWO_PHASE) begin
                nxt.hi = chop_i ? phase_bit(cur.top) : 3'b000;
                nxt.lo = phase_bit(cur.bot);
            end else if (!sector_i[0]) begin
                // common high side: steady phase and outgoing low side chopped
                nxt.hi = chop_i ? phase_bit(cur.top) : 3'b000;
                nxt.lo = phase_bit(cur.bot) | (chop_i ? phase_bit(prv.bot) : 3'b000);
            end else begin
                // common low side: steady phase and outgoing high side chopped
                nxt.lo = chop_i ? phase_bit(cur.bot) : 3'b000;
                nxt.hi = phase_bit(cur.top) | (chop_i ? phase_bit(prv.top) : 3'b000);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gates_o <= '0;
        else     gates_o <= nxt;
    end

    a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        (gates_o.hi & gates_o.lo) == 3'b000);

endmodule

// File: rtl/pwm_cmt_gen.sv
module pwm_cmt_gen
    import pwm_cmt_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_last_i,
    input  logic [2:0]       sector_i,
    input  logic             comm_i,
    input  logic [CNT_W-1:0] ton_norm_i,
    input  logic [CNT_W-1:0] ton_even_i,
    input  logic [CNT_W-1:0] ton_odd_i,
    output logic [2:0]       gate_hi_o,
    output logic [2:0]       gate_lo_o,
    output logic             chop_edge_o
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_s;
    logic [2:0]       sector_s;
    chop_mode_e       mode_s;
    logic [CNT_W-1:0] tn_s;
    logic [CNT_W-1:0] te_s;
    logic [CNT_W-1:0] to_s;
    logic             chop;
    gate_set_t        gates;

    pwm_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .last_i     (period_last_i),
        .sector_i   (sector_i),
        .comm_i     (comm_i),
        .ton_norm_i (ton_norm_i),
        .ton_even_i (ton_even_i),
        .ton_odd_i  (ton_odd_i),
        .cnt_o      (cnt),
        .last_o     (last_s),
        .sector_o   (sector_s),
        .mode_o     (mode_s),
        .ton_norm_o (tn_s),
        .ton_even_o (te_s),
        .ton_odd_o  (to_s)
    );

    pwm_chop_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .cnt_i      (cnt),
        .last_i     (last_s),
        .sector_i   (sector_s),
        .mode_i     (mode_s),
        .ton_norm_i (tn_s),
        .ton_even_i (te_s),
        .ton_odd_i  (to_s),
        .chop_o     (chop),
        .edge_o     (chop_edge_o)
    );

    pwm_gate_map u_map (
        .clk      (clk),
        .rst      (rst),
        .sector_i (sector_s),
        .mode_i   (mode_s),
        .chop_i   (chop),
        .gates_o  (gates)
    );

    assign gate_hi_o = gates.hi;
    assign gate_lo_o = gates.lo;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000 && !chop_edge_o));

    a_r8_invalid_sector_off: assert property (@(posedge clk) disable iff (rst)
        (sector_s == 3'd0 || sector_s == 3'd7) |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

endmodule

// File: tb/tb_pwm_cmt_gen.sv
`timescale 1ns/1ps
module tb_pwm_cmt_gen;

    localparam int CW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] period_last_i = '0;
    logic [2:0]    sector_i = 3'd0;
    logic          comm_i = 1'b0;
    logic [CW-1:0] ton_norm_i = '0;
    logic [CW-1:0] ton_even_i = '0;
    logic [CW-1:0] ton_odd_i = '0;
    logic [2:0]    gate_hi_o;
    logic [2:0]    gate_lo_o;
    logic          chop_edge_o;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pwm_cmt_gen #(.CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .period_last_i(period_last_i), .sector_i(sector_i),
        .comm_i(comm_i), .ton_norm_i(ton_norm_i), .ton_even_i(ton_even_i),
        .ton_odd_i(ton_odd_i), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o),
        .chop_edge_o(chop_edge_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int top_ph(input int s);
        case (s) 1, 2: return 0; 3, 4: return 1; default: return 2; endcase
    endfunction
    function automatic int bot_ph(input int s);
        case (s) 1, 6: return 1; 2, 3: return 2; default: return 0; endcase
    endfunction

    // 0 = off, 1 = held on, 2 = chopped
    function automatic int role(input int s, input bit m, input int ph, input bit hi_side);
        int pv;
        if (s < 1 || s > 6) return 0;
        pv = (s == 1) ? 6 : s - 1;
        if (!m) begin
            if (hi_side && ph == top_ph(s)) return 2;
            if (!hi_side && ph == bot_ph(s)) return 1;
            return 0;
        end
        if (s % 2 == 0) begin
            if (hi_side && ph == top_ph(s)) return 2;
            if (!hi_side && ph == bot_ph(s)) return 1;
            if (!hi_side && ph == bot_ph(pv)) return 2;
            return 0;
        end
        if (!hi_side && ph == bot_ph(s)) return 2;
        if (hi_side && ph == top_ph(s)) return 1;
        if (hi_side && ph == top_ph(pv)) return 2;
        return 0;
    endfunction

    function automatic int eff_on(input int s, input bit m, input int tn, input int te, input int to, input int p);
        int t;
        t = !m ? tn : ((s % 2 == 1) ? to : te);
        return (t > p) ? p : t;
    endfunction

    task automatic run_case(input int s, input bit m, input int last, input int tn, input int te,
                            input int to, input int k, input string req);
        int p, on, hc[3], lc[3], stb, shoot, e;
        @(negedge clk);
        sector_i = 3'(s); comm_i = m; period_last_i = CW'(last);
        ton_norm_i = CW'(tn); ton_even_i = CW'(te); ton_odd_i = CW'(to);
        repeat (2 * 64 + 4) @(negedge clk);
        p = last + 1;
        on = eff_on(s, m, tn, te, to, p);
        for (int i = 0; i < 3; i++) begin hc[i] = 0; lc[i] = 0; end
        stb = 0; shoot = 0;
        for (int c = 0; c < k * p; c++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) begin
                hc[i] += int'(gate_hi_o[i]);
                lc[i] += int'(gate_lo_o[i]);
            end
            stb += int'(chop_edge_o);
            if ((gate_hi_o & gate_lo_o) != 3'b000) shoot++;
        end
        for (int i = 0; i < 3; i++) begin
            for (int h = 0; h < 2; h++) begin
                int r = role(s, m, i, h[0]);
                e = (r == 0) ? 0 : (r == 1) ? k * p : k * on;
                chk((h ? hc[i] : lc[i]) == e, req, $sformatf("s=%0d m=%0d ph=%0d hi=%0d", s, m, i, h),
                    h ? hc[i] : lc[i], e);
            end
        end
        e = (on > 0 && on < p) ? 2 * k : 0;
        chk(stb == e, "R10", $sformatf("strobe s=%0d m=%0d", s, m), stb, e);
        chk(shoot == 0, "R9", "shoot-through cycles", shoot, 0);
    endtask

    function automatic string tag_of(input int s, input bit m);
        if (s < 1 || s > 6) return "R8";
        if (!m) return "R2";
        return (s % 2 == 0) ? "R3" : "R4";
    endfunction

    initial begin
        #(200000 * 5);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int cnt, found;
        void'($urandom(32'd7715));
        // R1: quiet during and right after reset
        sector_i = 3'd1; ton_norm_i = CW'(5); period_last_i = CW'(9);
        repeat (3) @(negedge clk);
        chk(gate_hi_o == 0 && gate_lo_o == 0 && !chop_edge_o, "R1", "outputs in reset",
            int'({gate_hi_o, gate_lo_o, chop_edge_o}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(gate_hi_o == 0 && gate_lo_o == 0 && !chop_edge_o, "R1", "outputs after reset",
            int'({gate_hi_o, gate_lo_o, chop_edge_o}), 0);

        // R2, R3, R4 directed: every valid sector in both modes
        for (int s = 1; s <= 6; s++) begin
            run_case(s, 1'b0, 15, 5, 9, 11, 1, "R2");
            run_case(s, 1'b1, 15, 5, 9, 11, 1, (s % 2 == 0) ? "R3" : "R4");
        end
        // R8 invalid sector codes
        run_case(0, 1'b0, 11, 4, 4, 4, 1, "R8");
        run_case(7, 1'b1, 11, 4, 6, 3, 1, "R8");
        // R5 on-time extremes
        run_case(2, 1'b0, 13, 0, 3, 3, 1, "R5");
        run_case(3, 1'b1, 13, 2, 2, 14, 1, "R5");
        run_case(4, 1'b1, 13, 1, 40, 1, 1, "R5");
        run_case(5, 1'b0, 13, 1, 2, 2, 1, "R5");
        // R6 period length over several periods, two lengths
        run_case(1, 1'b0, 9, 3, 3, 3, 4, "R6");
        run_case(6, 1'b1, 20, 2, 7, 2, 3, "R6");

        // R7: mid-period change must not affect the running period
        run_case(1, 1'b0, 15, 4, 4, 4, 1, "R7");
        found = 0;
        for (int c = 0; c < 40 && !found; c++) begin
            @(negedge clk);
            if (chop_edge_o && gate_hi_o[0]) found = 1;
        end
        chk(found == 1, "R7", "period start seen", found, 1);
        repeat (8) @(negedge clk);
        ton_norm_i = CW'(12);
        cnt = 0;
        for (int c = 9; c < 16; c++) begin
            @(negedge clk);
            cnt += int'(gate_hi_o[0]);
        end
        chk(cnt == 0, "R7", "on cycles in rest of old period", cnt, 0);
        cnt = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cnt += int'(gate_hi_o[0]);
        end
        chk(cnt == 12, "R7", "on cycles in next period", cnt, 12);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int s = int'($urandom_range(0, 7));
            bit m = 1'($urandom_range(0, 1));
            int l = int'($urandom_range(5, 20));
            run_case(s, m, l, int'($urandom_range(0, l + 3)), int'($urandom_range(0, l + 3)),
                     int'($urandom_range(0, l + 3)), 1, tag_of(s, m));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule